// File: doc/BRIEF.md
# PDM Microphone Clock Generator and Bit Sampler

This block drives the clock pin of a pulse-density-modulated microphone and collects one data bit from it in each microphone clock period. The microphone clock is made from the 100 MHz system clock by a counter that flips a registered output every 21 system cycles. The result is a 42-cycle period, about 2.38 MHz, with an even duty cycle. The microphone clock is only ever a registered output pin. It never clocks any logic inside the block, so the whole design lives in the system clock domain.

A microphone of this kind puts a bit on its data line only for a short time after a clock transition. Which transition it answers depends on how it is strapped. An edge-select input therefore picks the rising or the falling transition. A short capture window is timed from that transition, a fixed parameterised number of system cycles later. The bit taken in that window is the data pin after a two-flop synchroniser. It is presented together with a one-cycle valid pulse.

A separate one-cycle strobe marks each rising transition of the microphone clock. Downstream bit counters can use it, for example to group sixteen bits into a word.

Top module: `pdm_mic_sampler`

## Requirements
- R1: While reset is high, and on the first cycle after it, the microphone clock is low and the rising strobe, valid pulse and captured bit are all 0.
- R2: Counting N as the number of rising system clock edges since reset was released, the microphone clock is high exactly when floor(N/21) is odd. It therefore toggles every 21 system cycles, with a 42-cycle period.
- R3: The rising strobe is high for exactly one system cycle: the first cycle in which the microphone clock reads high (N mod 42 = 21).
- R4: With edge-select 0 (rising edge), valid pulses exactly when N mod 42 = 21 + D + 1, where D is the capture delay (default 3). There is one pulse per microphone clock period.
- R5: With edge-select 1 (falling edge), valid pulses exactly when N mod 42 = D + 1 and N is at least 42. No capture occurs before the first falling transition after reset.
- R6: On a valid pulse, the captured bit equals the data pin value that was held since the selected transition. A pin change that arrives within the last two system cycles before the capture window is not taken.
- R7: Valid is never high on two consecutive cycles, and the captured bit holds its value between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| edgeSel | input | 1 | 0: capture after rising microphone clock edge; 1: after falling edge |
| micData | input | 1 | Serial data from the microphone (asynchronous) |
| micClk | output | 1 | Registered microphone clock, about 2.38 MHz |
| riseStb | output | 1 | One-cycle strobe on each microphone clock rising edge |
| dataBit | output | 1 | Most recently captured microphone bit |
| dataValid | output | 1 | One-cycle pulse when dataBit has just been updated |

## Verification
Two things can coincide in the same system cycle. One is a fresh transition on the data pin entering the synchroniser. The other is the capture window closing on the bit that was already settled. The bench provokes this by flipping the pin for one cycle, timed so that the flip reaches only the first synchroniser flop on the capture cycle. It then judges the captured bit against the value the pin held since the selected edge, not against the flipped value. A second overlap is the edge-select change: the bench switches it at period boundaries and checks that captures move from one half-period to the other with no pulse lost or duplicated.

// File: rtl/pdm_mic_pkg.sv
package pdm_mic_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic riseStb;   // microphone clock has just gone high
    logic capStb;    // capture window: take the synchronised bit now
  } pdmStrobes_t;

  localparam int DEF_HALF_DIV      = 21;
  localparam int DEF_CAPTURE_DELAY = 3;
  localparam int DEF_SYNC_STAGES   = 2;

endpackage

// File: rtl/pdm_mic_ctrl.sv
module pdm_mic_ctrl
  import pdm_mic_pkg::*;
#(
  parameter int HALF_DIV      = DEF_HALF_DIV,
  parameter int CAPTURE_DELAY = DEF_CAPTURE_DELAY
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        edgeSel,
  output logic        micClk,
  output pdmStrobes_t strobes
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] CAP_CNT  = CNT_W'(CAPTURE_DELAY - 1);

  logic [CNT_W-1:0] divCnt;
  logic             armed;      // set once the first clock transition has happened
  logic             wrapNow;
  logic             windowHit;

  assign wrapNow   = (divCnt == LAST_CNT);
  // Count reaches CAP_CNT in the half-period whose level follows the chosen edge
  assign windowHit = armed && (divCnt == CAP_CNT) && (micClk == !edgeSel);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      micClk  <= 1'b0;
      armed   <= 1'b0;
      strobes <= '0;
    end else begin
      if (wrapNow) begin
        divCnt <= '0;
        micClk <= ~micClk;
        armed  <= 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      strobes.riseStb <= wrapNow && !micClk;
      strobes.capStb  <= windowHit;
    end
  end

  // Check: reset holds the clock low (R1)
  logic pastRst;
  always_ff @(posedge clk) pastRst <= rst;
  always @(posedge clk) begin
    if (pastRst) begin
      p_clk_low_rst_r1: assert (!micClk && strobes == '0)
        else $error("micClk or strobes not cleared by reset");
    end
  end

  // Check: the clock only changes after a full half-period count (R2)
  p_half_period_r2: assert property (@(posedge clk) disable iff (rst)
    (micClk != $past(micClk)) |-> ($past(divCnt) == LAST_CNT));

  // Check: the rising strobe coincides with the first high cycle (R3)
  p_rise_edge_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.riseStb |-> (micClk && !$past(micClk)));

  // Check: a capture window lies in the half-period selected by edgeSel (R5)
  p_cap_level_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.capStb |-> (micClk == !$past(edgeSel)));

endmodule

// File: rtl/pdm_mic_dp.sv
module pdm_mic_dp
  import pdm_mic_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        micData,
  input  pdmStrobes_t strobes,
  output logic        dataBit,
  output logic        dataValid
);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   syncBit;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) syncReg <= '0;
        else     syncReg <= micData;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) syncReg <= '0;
        else     syncReg <= {syncReg[SYNC_STAGES-2:0], micData};
      end
    end
  endgenerate

  assign syncBit = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dataBit   <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobes.capStb;
      if (strobes.capStb) dataBit <= syncBit;
    end
  end

  // Check: valid only follows a capture window (R4)
  p_valid_after_cap_r4: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> $past(strobes.capStb));

  // Check: valid is a single-cycle pulse (R7)
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);

  // Check: captured bit holds without a valid pulse (R7)
  p_bit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !dataValid |-> $stable(dataBit));

endmodule

// File: rtl/pdm_mic_sampler.sv
module pdm_mic_sampler
  import pdm_mic_pkg::*;
#(
  parameter int HALF_DIV      = DEF_HALF_DIV,
  parameter int CAPTURE_DELAY = DEF_CAPTURE_DELAY,
  parameter int SYNC_STAGES   = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic edgeSel,
  input  logic micData,
  output logic micClk,
  output logic riseStb,
  output logic dataBit,
  output logic dataValid
);

  pdmStrobes_t strobes;

  pdm_mic_ctrl #(
    .HALF_DIV      (HALF_DIV),
    .CAPTURE_DELAY (CAPTURE_DELAY)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .edgeSel (edgeSel),
    .micClk  (micClk),
    .strobes (strobes)
  );

  pdm_mic_dp #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .micData   (micData),
    .strobes   (strobes),
    .dataBit   (dataBit),
    .dataValid (dataValid)
  );

  assign riseStb = strobes.riseStb;

endmodule

// File: tb/pdm_mic_sampler_test.sv
module pdm_mic_sampler_test;

  localparam int HALF = 21;
  localparam int D    = 3;
  localparam int PER  = 2 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic edgeSel = 1'b0;
  logic micData = 1'b0;
  logic micClk, riseStb, dataBit, dataValid;

  int total = 0;
  int bad = 0;
  int n = 0;
  logic [31:0] pat = 32'hA5C3_3C96;
  logic glitchOn = 1'b0;
  logic lastExp = 1'b0;
  logic haveBit = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  pdm_mic_sampler uut (
    .clk(clk), .rst(rst), .edgeSel(edgeSel), .micData(micData),
    .micClk(micClk), .riseStb(riseStb), .dataBit(dataBit), .dataValid(dataValid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at n=%0d actual=%0d expected=%0d", req, n, act, exp);
    end
  endtask

  // One system cycle: sample at the falling edge, then drive the pin
  task automatic step();
    logic expClk, expRise, expV;
    @(negedge clk);
    if (rst) begin
      chk(micClk == 1'b0, "R1 micClk", micClk, 0);
      chk(!riseStb && !dataValid && !dataBit, "R1 strobes", {riseStb, dataValid, dataBit}, 0);
      haveBit = 1'b0;
    end else begin
      expClk  = ((n / HALF) % 2) == 1;
      expRise = (n % PER) == HALF;
      expV    = edgeSel ? (n >= PER && (n % PER) == D + 1)
                        : ((n % PER) == HALF + D + 1);
      chk(micClk == expClk, "R2 micClk", micClk, expClk);
      chk(riseStb == expRise, "R3 riseStb", riseStb, expRise);
      chk(dataValid == expV, edgeSel ? "R5 dataValid" : "R4 dataValid", dataValid, expV);
      if (expV) begin
        lastExp = pat[((n - 1 - D) / HALF) % 32];
        haveBit = 1'b1;
        chk(dataBit == lastExp, "R6 dataBit", dataBit, lastExp);
      end else if (haveBit) begin
        chk(dataBit == lastExp, "R7 hold", dataBit, lastExp);
      end else if (n == 1) begin
        chk(dataBit == 1'b0, "R1 first cycle", dataBit, 0);
      end
    end
    micData = rst ? 1'b0 : (pat[(n / HALF) % 32] ^ (glitchOn && (n % HALF) == D - 1));
  endtask

  task automatic runCycles(input int cnt);
    for (int i = 0; i < cnt; i++) step();
  endtask

  // Move to the cycle just before a period boundary
  task automatic alignPeriod();
    while ((n % PER) != PER - 1) step();
  endtask

  task automatic testReset();   // R1
    rst = 1'b1;
    runCycles(5);
    rst = 1'b0;
    runCycles(3);
  endtask

  task automatic testRising();  // R2 R3 R4 R6 R7
    edgeSel = 1'b0;
    pat = 32'hA5C3_3C96;
    runCycles(PER * 8);
  endtask

  task automatic testFalling(); // R5 R6 R7
    alignPeriod();
    edgeSel = 1'b1;
    pat = 32'h6E19_D2B4;
    runCycles(PER * 8);
  endtask

  task automatic testGlitch();  // R6: late pin flip in the capture cycle
    alignPeriod();
    edgeSel = 1'b0;
    glitchOn = 1'b1;
    runCycles(PER * 6);
    alignPeriod();
    edgeSel = 1'b1;
    runCycles(PER * 6);
    glitchOn = 1'b0;
  endtask

  task automatic testMidReset(); // R1 R2 R5: reset mid high phase, restart in falling mode
    while ((n % PER) != HALF + 5) step();
    rst = 1'b1;
    runCycles(3);
    edgeSel = 1'b1;
    rst = 1'b0;
    runCycles(PER * 4);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testRising();
    testFalling();
    testGlitch();
    testMidReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule